// File: doc/BRIEF.md
# Timestamp Compare Channel Array

This block sits beside a free-running 31-bit nanosecond timestamp counter and gives it a small set of output-compare channels. The counter advances by a fixed step every clock and wraps modulo 2^31. Each channel holds a compare value. When the counter passes that value, the channel sets a sticky event flag, can request an interrupt, and drives its own output pin. Depending on the channel mode, the pin either toggles or gives a one-cycle high pulse. A typical use is a once-per-second output: software arms the first edge, queues the next one, and then refills the queue at each event.

Software reaches the channels over a plain register bus. Each channel has a control/status word and a compare word, and one status word collects all channel flags. The compare word has two stages. The first value written while the channel is off becomes the armed value. A value written while an armed value is pending waits behind it and takes over at the next match, so software always works one event ahead. A separate enable input gates all match events, for example from a timer-control bit that lives outside this block.

Top module: `tscmp_top`

## Requirements
- R1: After a synchronous reset, `tstamp` equals `CNT_INIT`, all pins and `irq` are low, and every register reads 0.
- R2: `tstamp` increases by `INC` on every clock edge, modulo 2^31.
- R3: The channel n control word is at byte address 0x608+8n and the compare word is at 0x60C+8n. In the control word, bit 0 is a request-enable bit that is stored with no effect, bits 5:2 are the mode, bit 6 is the interrupt enable and bit 7 is the event flag. All of these read back. Read data appears on `rdata` one clock after `bus_rd`, and the compare word reads back the armed value.
- R4: A compare value written while the mode is 0 becomes the armed value. Once the mode is nonzero, the channel matches on the clock edge that moves `tstamp` into the range [V, V+INC). That edge sets the flag.
- R5: In mode 0xF the pin is high for exactly one cycle: the cycle right after the matching edge.
- R6: In mode 0x5 the pin inverts at each match and holds its level between matches.
- R7: A compare write while the mode is nonzero and an armed value is pending goes to a one-entry queue, and a later write replaces the queued value. At a match, the queued value becomes armed. With nothing queued, the channel stays idle. A write while nothing is armed arms the value directly.
- R8: Writing the control word with bit 7 = 1 clears the flag. Writing bit 7 = 0 leaves the flag as it is.
- R9: `irq` is the OR over all channels of flag AND interrupt enable, registered one cycle behind the flags.
- R10: The word at 0x604 returns the channel flags in bits 3:0, with channel n in bit n.
- R11: Writing a control word whose mode is 0 disables the channel: the pin goes low, the armed and queued values are dropped, and no further match occurs.
- R12: Matches work across the 2^31 wrap of the counter.
- R13: While `match_en` is low, no match occurs: no flag, no pin activity, and the armed value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_en | input | 1 | Gates all compare events |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| tstamp | output | 31 | Current counter value |
| cmp_pin | output | 4 | Per-channel compare outputs |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the two-stage compare ordering. Two writes have to land while an earlier match is still pending, and the bench then has to show that the second write replaced the first queued value, so that the event after the armed one lands at the last value written and not at the middle one. Each scenario picks its compare values relative to the sampled counter, so every event falls a known number of cycles ahead. The bench checks each pin edge against the range [V, V+INC) computed from `tstamp`. The wrap case resets the counter to a start value just below 2^31 and arms a value just above zero.

// File: rtl/tscmp_pkg.sv
package tscmp_pkg;
  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  // control word layout: flag in bit 7, irq enable 6, mode 5:2, bit 1 zero, request enable 0
  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [3:0] mode;
    logic       rsvd;
    logic       dreq;
  } ctl_t;
endpackage

// File: rtl/tscmp_counter.sv
module tscmp_counter #(
  parameter int              CNT_W    = 31,
  parameter int              INC      = 8,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(INC);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_INIT;
    else     cnt_q <= cnt_q + STEP;
  end
endmodule

// File: rtl/tscmp_regdec.sv
module tscmp_regdec #(
  parameter int ADDR_W   = 12,
  parameter int NCH      = 4,
  parameter int STAT_ADR = 'h604,
  parameter int CTL_BASE = 'h608,
  parameter int CMP_BASE = 'h60C,
  parameter int STRIDE   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              stat_sel,
  output logic [NCH-1:0]    ctl_sel,
  output logic [NCH-1:0]    cmp_sel
);
  assign stat_sel = (addr == ADDR_W'(STAT_ADR));

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_BASE + STRIDE * n);
    localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CMP_BASE + STRIDE * n);
    assign ctl_sel[n] = (addr == CTL_A);
    assign cmp_sel[n] = (addr == CMP_A);
  end
endmodule

// File: rtl/tscmp_channel.sv
module tscmp_channel
  import tscmp_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter int INC   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             match_en,
  input  logic             ctl_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] act_q,
  output logic             pin_q
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(INC);

  logic             actv_q, hold_v_q;
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] gap;
  logic             hit;

  ctl_t             ctl_n;
  logic [CNT_W-1:0] act_n, hold_n;
  logic             actv_n, hold_v_n, pin_n;
  ctl_t             wctl;

  // distance from the counter to the armed value; the next step crosses it when 1..INC
  assign gap  = act_q - cnt;
  assign hit  = match_en && actv_q && (ctl_q.mode != MODE_OFF)
                && (gap != '0) && (gap <= STEP);
  assign wctl = ctl_t'(wdata[7:0]);

  always_comb begin
    ctl_n    = ctl_q;
    act_n    = act_q;
    actv_n   = actv_q;
    hold_n   = hold_q;
    hold_v_n = hold_v_q;

    if (hit) begin
      if (hold_v_q) begin
        act_n    = hold_q;
        actv_n   = 1'b1;
        hold_v_n = 1'b0;
      end else begin
        actv_n = 1'b0;
      end
    end

    if (cmp_we) begin
      if (ctl_q.mode == MODE_OFF || !actv_n) begin
        act_n  = wdata;
        actv_n = 1'b1;
      end else begin
        hold_n   = wdata;
        hold_v_n = 1'b1;
      end
    end

    if (ctl_we) begin
      ctl_n.dreq = wctl.dreq;
      ctl_n.ie   = wctl.ie;
      ctl_n.mode = wctl.mode;
      if (wctl.flag) ctl_n.flag = 1'b0;
      if (wctl.mode == MODE_OFF) begin
        actv_n   = 1'b0;
        hold_v_n = 1'b0;
      end
    end
    if (hit) ctl_n.flag = 1'b1;
    ctl_n.rsvd = 1'b0;

    if (ctl_we && wctl.mode == MODE_OFF) pin_n = 1'b0;
    else begin
      case (ctl_q.mode)
        MODE_TOGGLE: pin_n = pin_q ^ hit;
        MODE_PULSE:  pin_n = hit;
        default:     pin_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      act_q    <= '0;
      actv_q   <= 1'b0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      pin_q    <= 1'b0;
    end else begin
      ctl_q    <= ctl_n;
      act_q    <= act_n;
      actv_q   <= actv_n;
      hold_q   <= hold_n;
      hold_v_q <= hold_v_n;
      pin_q    <= pin_n;
    end
  end
endmodule

// File: rtl/tscmp_top.sv
module tscmp_top
  import tscmp_pkg::*;
#(
  parameter int               CNT_W    = 31,
  parameter int               INC      = 8,
  parameter logic [CNT_W-1:0] CNT_INIT = '0,
  parameter int               NCH      = 4,
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  tstamp,
  output logic [NCH-1:0]    cmp_pin,
  output logic              irq
);
  logic             stat_sel;
  logic [NCH-1:0]   ctl_sel, cmp_sel;
  logic [NCH-1:0]   flag_vec, ie_vec;
  logic [4*NCH-1:0] mode_vec;
  ctl_t             ctl_rd [NCH];
  logic [CNT_W-1:0] act_rd [NCH];
  logic [DATA_W-1:0] rd_mux;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:CNT_W];

  tscmp_counter #(.CNT_W(CNT_W), .INC(INC), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst(rst), .cnt_q(tstamp)
  );

  tscmp_regdec #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr(bus_addr), .stat_sel(stat_sel), .ctl_sel(ctl_sel), .cmp_sel(cmp_sel)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tscmp_channel #(.CNT_W(CNT_W), .INC(INC)) u_ch (
      .clk(clk), .rst(rst), .cnt(tstamp), .match_en(match_en),
      .ctl_we(bus_wr && ctl_sel[n]), .cmp_we(bus_wr && cmp_sel[n]),
      .wdata(bus_wdata[CNT_W-1:0]),
      .ctl_q(ctl_rd[n]), .act_q(act_rd[n]), .pin_q(cmp_pin[n])
    );
    assign flag_vec[n]         = ctl_rd[n].flag;
    assign ie_vec[n]           = ctl_rd[n].ie;
    assign mode_vec[4*n +: 4]  = ctl_rd[n].mode;
  end

  always_comb begin
    rd_mux = '0;
    if (stat_sel) rd_mux[NCH-1:0] = flag_vec;
    for (int n = 0; n < NCH; n++) begin
      if (ctl_sel[n]) rd_mux[7:0]       = ctl_rd[n];
      if (cmp_sel[n]) rd_mux[CNT_W-1:0] = act_rd[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (bus_rd) rdata <= rd_mux;
      irq <= |(flag_vec & ie_vec);
    end
  end
endmodule

// File: rtl/tscmp_checker.sv
module tscmp_checker #(
  parameter int CNT_W  = 31,
  parameter int INC    = 8,
  parameter int NCH    = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wbit7,
  input logic [CNT_W-1:0]  tstamp,
  input logic [NCH-1:0]    pins,
  input logic              irq,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    ies,
  input logic [4*NCH-1:0]  modes
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tstamp == CNT_W'($past(tstamp) + CNT_W'(INC))); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(flags & ies))); // R9

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'('h608 + 8 * n);

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[n]) |-> $past(bus_wr && bus_addr == CTL_A && wbit7)); // R8

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
      modes[4*n +: 4] == 4'h0 |=> !pins[n]); // R11
  end
endmodule

bind tscmp_top tscmp_checker #(.CNT_W(CNT_W), .INC(INC), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .wbit7(bus_wdata[7]),
  .tstamp(tstamp), .pins(cmp_pin), .irq(irq),
  .flags(flag_vec), .ies(ie_vec), .modes(mode_vec)
);

// File: tb/tscmp_top_test.sv
module tscmp_top_test;
  localparam int          INC   = 4;
  localparam logic [30:0] INIT  = 31'h7FFF_F000;
  localparam logic [30:0] MASK  = 31'h7FFF_FFFF;
  localparam logic [11:0] STAT  = 12'h604;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        match_en = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata;
  logic [30:0] tstamp;
  logic [3:0]  cmp_pin;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  tscmp_top #(.INC(INC), .CNT_INIT(INIT)) uut (
    .clk(clk), .rst(rst), .match_en(match_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rdata(rdata), .tstamp(tstamp),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [11:0] ctl_a(int n); return 12'(12'h608 + 8 * n); endfunction
  function automatic logic [11:0] cmp_a(int n); return 12'(12'h60C + 8 * n); endfunction
  function automatic bit in_win(logic [30:0] ts, logic [30:0] v);
    return ((ts - v) & MASK) < 31'(INC);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0; d = rdata;
  endtask

  task automatic wait_level(int ch, logic lvl, output logic [30:0] ts, output bit found);
    found = 1'b0; ts = '0;
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk);
      if (cmp_pin[ch] == lvl) begin found = 1'b1; ts = tstamp; end
    end
  endtask

  task automatic quiet(int ch, int cyc, string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (cmp_pin[ch]) seen = 1'b1;
    end
    chk(!seen, req, 32'(seen), 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(tstamp == INIT, "R1 tstamp", 32'(tstamp), 32'(INIT));
    chk(cmp_pin == 0 && irq == 0, "R1 outputs", {27'b0, cmp_pin, irq}, 0);
    rd(STAT, d);      chk(d == 0, "R1 status", d, 0);
    rd(ctl_a(2), d);  chk(d == 0, "R1 ctl", d, 0);
    rd(cmp_a(1), d);  chk(d == 0, "R1 cmp", d, 0);
  endtask

  task automatic t_count();
    logic [30:0] a;
    @(negedge clk); a = tstamp;
    repeat (10) @(negedge clk);
    chk(tstamp == 31'(a + 40), "R2 step", 32'(tstamp), 32'(31'(a + 40)));
  endtask

  task automatic t_ctl_rw();
    logic [31:0] d;
    wr(ctl_a(1), 32'h41); rd(ctl_a(1), d); chk(d == 32'h41, "R3 readback", d, 32'h41);
    wr(ctl_a(1), 32'h0C); rd(ctl_a(1), d); chk(d == 32'h0C, "R3 mode", d, 32'h0C);
    wr(ctl_a(1), 32'h00);
  endtask

  task automatic t_pulse();
    logic [31:0] d; logic [30:0] v, ts; bit f;
    v = 31'(tstamp + 400);
    wr(cmp_a(0), 32'(v)); wr(ctl_a(0), 32'h7C);
    rd(cmp_a(0), d); chk(d == 32'(v), "R3 cmp readback", d, 32'(v));
    wait_level(0, 1'b1, ts, f);
    chk(f && in_win(ts, v), "R4 match point", 32'(ts), 32'(v));
    chk(irq == 1'b0, "R9 lag", 32'(irq), 0);
    @(negedge clk);
    chk(cmp_pin[0] == 1'b0, "R5 one cycle", 32'(cmp_pin[0]), 0);
    chk(irq == 1'b1, "R9 raise", 32'(irq), 1);
    rd(STAT, d); chk(d == 32'h1, "R10 status", d, 32'h1);
    rd(ctl_a(0), d); chk(d == 32'hFC, "R4 flag", d, 32'hFC);
    wr(ctl_a(0), 32'h7C); rd(ctl_a(0), d); chk(d == 32'hFC, "R8 write zero", d, 32'hFC);
    wr(ctl_a(0), 32'hFC); rd(ctl_a(0), d); chk(d == 32'h7C, "R8 clear", d, 32'h7C);
    chk(irq == 1'b0, "R9 drop", 32'(irq), 0);
    wr(ctl_a(0), 32'h0);
  endtask

  task automatic t_toggle();
    logic [31:0] d; logic [30:0] v1, v2, ts; bit f, held;
    v1 = 31'(tstamp + 400); v2 = 31'(tstamp + 800);
    wr(cmp_a(2), 32'(v1)); wr(ctl_a(2), 32'h14); wr(cmp_a(2), 32'(v2));
    wait_level(2, 1'b1, ts, f);
    chk(f && in_win(ts, v1), "R6 first edge", 32'(ts), 32'(v1));
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!cmp_pin[2]) held = 1'b0; end
    chk(held, "R6 hold", 32'(held), 1);
    wait_level(2, 1'b0, ts, f);
    chk(f && in_win(ts, v2), "R6 second edge", 32'(ts), 32'(v2));
    chk(irq == 1'b0, "R9 ie off", 32'(irq), 0);
    rd(STAT, d); chk(d == 32'h4, "R10 channel 2", d, 32'h4);
    wr(ctl_a(2), 32'h80);
  endtask

  task automatic t_queue();
    logic [31:0] d; logic [30:0] v1, v2, v3, ts; bit f;
    v1 = 31'(tstamp + 400); v2 = 31'(tstamp + 800); v3 = 31'(tstamp + 1200);
    wr(cmp_a(3), 32'(v1)); wr(ctl_a(3), 32'h3C);
    wr(cmp_a(3), 32'(v2)); wr(cmp_a(3), 32'(v3));
    wait_level(3, 1'b1, ts, f);
    chk(f && in_win(ts, v1), "R7 armed first", 32'(ts), 32'(v1));
    rd(cmp_a(3), d); chk(d == 32'(v3), "R7 queued replaced", d, 32'(v3));
    wait_level(3, 1'b1, ts, f);
    chk(f && in_win(ts, v3), "R7 second event", 32'(ts), 32'(v3));
    quiet(3, 300, "R7 idle after queue empty");
  endtask

  task automatic t_disable();
    logic [31:0] d; logic [30:0] v4, v5;
    v4 = 31'(tstamp + 400); v5 = 31'(tstamp + 600);
    wr(cmp_a(3), 32'(v4)); wr(cmp_a(3), 32'(v5));
    wr(ctl_a(3), 32'h80);
    rd(ctl_a(3), d); chk(d == 0, "R11 ctl", d, 0);
    quiet(3, 250, "R11 no match");
    rd(STAT, d); chk(d[3] == 1'b0, "R11 status", d, 0);
  endtask

  task automatic t_gate();
    logic [31:0] d; logic [30:0] v;
    match_en = 1'b0;
    v = 31'(tstamp + 200);
    wr(cmp_a(1), 32'(v)); wr(ctl_a(1), 32'h3C);
    quiet(1, 150, "R13 no pin");
    rd(STAT, d); chk(d[1] == 1'b0, "R13 no flag", d, 0);
    rd(cmp_a(1), d); chk(d == 32'(v), "R13 value kept", d, 32'(v));
    match_en = 1'b1;
    wr(ctl_a(1), 32'h0);
  endtask

  task automatic t_wrap();
    logic [30:0] ts; bit f;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(tstamp == INIT, "R1 re-reset", 32'(tstamp), 32'(INIT));
    wr(cmp_a(0), 32'h10); wr(ctl_a(0), 32'h3C);
    wait_level(0, 1'b1, ts, f);
    chk(f && in_win(ts, 31'h10), "R12 wrap match", 32'(ts), 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_ctl_rw();
    t_pulse();
    t_toggle();
    t_queue();
    t_disable();
    t_gate();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule